// File: doc/BRIEF.md
# Termination calibration sequencer

This controller runs in the user calibration clock domain and drives the strobes that several on-chip termination calibration engines and their I/O banks need. A start request carries a mask of the engines to service. The controller first runs a calibration window for each selected engine, one engine at a time. It then drops the global calibration enable and unloads each engine's 28-bit code (14 series-termination bits and 14 parallel-termination bits) over a serial window. Each engine is unloaded in turn. The analog engines and the bank-side shift registers are outside this block.

Each bank has a parallel-update enable. It fires once its engine's code has fully arrived, and its width meets a minimum time given in clock cycles. While a bank's update enable is high, that bank's I/Os must not carry data. A busy flag spans the whole sequence, and a one-cycle done pulse closes it. The number of engines, the bank-to-engine map, the window lengths and the update width are all parameters.

Top module: `term_cal_seq`

## Requirements
- R1: While rst_ni is low and after its release with no accepted start: cal_en_o=0, clr_no=1, ser_en_o=0, upd_en_o=0, busy_o=0, done_o=0.
- R2: A start_i sampled high while busy_o is low is accepted only if eng_sel_i is nonzero. With a zero mask nothing happens and every output keeps its idle value.
- R3: Cycle 0 is the cycle after an accepted start. Selected engines are calibrated in ascending index order, and engine position j (0-based) uses the cycles from j*(CAL_CYCLES+1). In its first cycle clr_no=0, cal_en_o=1 and ser_en_o=0. In the next CAL_CYCLES cycles only bit k of ser_en_o is high.
- R4: cal_en_o is high from cycle 0 through cycle m*(CAL_CYCLES+1), for m selected engines. That last cycle is the one right after the final calibration window, and all serial enables are low in it. The next cycle has cal_en_o=0 and no serial enable.
- R5: Transfer starts at X0=m*(CAL_CYCLES+1)+2. Engine position j holds only its bit of ser_en_o for exactly CODE_BITS cycles, starting at X0+j*(CODE_BITS+1), so one all-low cycle separates consecutive windows. The order is ascending index.
- R6: ser_en_o never has more than one bit set.
- R7: Each bank b maps to engine BANK_MAP[8*b +: 8]. Its upd_en_o[b] rises in the cycle right after the last cycle of that engine's transfer window and stays high for exactly UPD_CYCLES cycles. Banks whose engine is not selected stay low.
- R8: busy_o is high from cycle 0 through the last cycle of the last update pulse. In the next cycle busy_o=0 and done_o=1, and done_o lasts one cycle.
- R9: start_i and eng_sel_i are ignored while busy_o is high. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User calibration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| eng_sel_i | input | N_ENG | Engines to service, sampled with an accepted start |
| cal_en_o | output | 1 | Global calibration enable |
| clr_no | output | 1 | Active-low user clear |
| ser_en_o | output | N_ENG | Per-engine serial enable, one-hot or zero |
| upd_en_o | output | N_BANK | Per-bank parallel-update enable; the bank's I/Os are unusable while high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with four engines and six banks. Engines 0 and 3 each serve two banks, engines 1 and 2 serve one each, CAL_CYCLES is the full 1000 and CODE_BITS is 28. A 10 ns clock gives an update width of 3 cycles. This setup covers a single engine, the lowest and highest index alone, sparse masks and the full mask, with bank pulses from one engine overlapping the next engine's transfer. Every output is compared on every cycle against a cycle-indexed model, including while ignored start requests with random masks arrive mid-sequence.

// File: rtl/term_cal_pkg.sv
package term_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,   // clear low, global enable high
    ST_CAL,
    ST_TAIL,   // global enable held one cycle after last window
    ST_GAP,    // global enable low before transfer
    ST_XFER,
    ST_XGAP,
    ST_DRAIN   // wait for update pulses
  } seq_st_e;
endpackage

// File: rtl/term_cal_pick.sv
module term_cal_pick #(
  parameter int unsigned N_ENG = 4,
  localparam int unsigned EW = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
  input  logic [N_ENG-1:0] mask_i,
  output logic [EW-1:0]    idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = EW'(i);
    end
  end
endmodule

// File: rtl/term_cal_upd.sv
module term_cal_upd #(
  parameter int unsigned UPD_CYCLES = 3,
  localparam int unsigned UW = $clog2(UPD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic upd_o,
  output logic hold_o
);
  localparam logic [UW-1:0] UPD_LOAD = UW'(UPD_CYCLES);

  logic [UW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= UPD_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign upd_o  = (cnt_q != '0);
  assign hold_o = (cnt_q > UW'(1));
endmodule

// File: rtl/term_cal_fsm.sv
module term_cal_fsm
  import term_cal_pkg::*;
#(
  parameter int unsigned N_ENG      = 4,
  parameter int unsigned CAL_CYCLES = 1000,
  parameter int unsigned CODE_BITS  = 28,
  localparam int unsigned EW = (N_ENG > 1) ? $clog2(N_ENG) : 1,
  localparam int unsigned CMAX = (CAL_CYCLES > CODE_BITS) ? CAL_CYCLES : CODE_BITS,
  localparam int unsigned CW = $clog2(CMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_ENG-1:0] sel_i,
  input  logic             hold_i,
  output logic             cal_en_o,
  output logic             clr_no,
  output logic [N_ENG-1:0] ser_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             xfer_end_o,
  output logic [EW-1:0]    eng_o
);
  localparam logic [CW-1:0] CAL_LAST  = CW'(CAL_CYCLES - 1);
  localparam logic [CW-1:0] CODE_LAST = CW'(CODE_BITS - 1);

  seq_st_e          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [EW-1:0]    eng_q, eng_d;
  logic [N_ENG-1:0] sel_q, sel_d;
  logic [N_ENG-1:0] pend_q, pend_d;
  logic [N_ENG-1:0] pick_src;
  logic [EW-1:0]    pick_idx;
  logic [N_ENG-1:0] pick_oh;

  always_comb begin
    unique case (st_q)
      ST_IDLE: pick_src = sel_i;
      ST_GAP:  pick_src = sel_q;
      default: pick_src = pend_q;
    endcase
  end

  term_cal_pick #(.N_ENG(N_ENG)) i_pick (
    .mask_i (pick_src),
    .idx_o  (pick_idx)
  );

  assign pick_oh = N_ENG'(1) << pick_idx;

  assign xfer_end_o = (st_q == ST_XFER) && (cnt_q == CODE_LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    eng_d  = eng_q;
    sel_d  = sel_q;
    pend_d = pend_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i && (sel_i != '0)) begin
          sel_d  = sel_i;
          eng_d  = pick_idx;
          pend_d = sel_i & ~pick_oh;
          st_d   = ST_PREP;
        end
      end
      ST_PREP: begin
        cnt_d = '0;
        st_d  = ST_CAL;
      end
      ST_CAL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CAL_LAST) begin
          if (pend_q != '0) begin
            eng_d  = pick_idx;
            pend_d = pend_q & ~pick_oh;
            st_d   = ST_PREP;
          end else begin
            st_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: st_d = ST_GAP;
      ST_GAP: begin
        eng_d  = pick_idx;
        pend_d = sel_q & ~pick_oh;
        cnt_d  = '0;
        st_d   = ST_XFER;
      end
      ST_XFER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CODE_LAST) st_d = (pend_q != '0) ? ST_XGAP : ST_DRAIN;
      end
      ST_XGAP: begin
        eng_d  = pick_idx;
        pend_d = pend_q & ~pick_oh;
        cnt_d  = '0;
        st_d   = ST_XFER;
      end
      ST_DRAIN: begin
        if (!hold_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      eng_q    <= '0;
      sel_q    <= '0;
      pend_q   <= '0;
      cal_en_o <= 1'b0;
      clr_no   <= 1'b1;
      ser_en_o <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      eng_q    <= eng_d;
      sel_q    <= sel_d;
      pend_q   <= pend_d;
      cal_en_o <= (st_d == ST_PREP) || (st_d == ST_CAL) || (st_d == ST_TAIL);
      clr_no   <= (st_d != ST_PREP);
      ser_en_o <= ((st_d == ST_CAL) || (st_d == ST_XFER)) ? (N_ENG'(1) << eng_d) : '0;
      busy_o   <= (st_d != ST_IDLE);
      done_o   <= (st_q == ST_DRAIN) && (st_d == ST_IDLE);
    end
  end

  assign eng_o = eng_q;
endmodule

// File: rtl/term_cal_seq.sv
module term_cal_seq #(
  parameter int unsigned N_ENG      = 4,
  parameter int unsigned N_BANK     = 6,
  parameter int unsigned CAL_CYCLES = 1000,
  parameter int unsigned CODE_BITS  = 28,
  parameter int unsigned UPD_CYCLES = 3,
  // 8 bits per bank: engine index serving that bank
  parameter logic [N_BANK*8-1:0] BANK_MAP = 48'h03_03_02_01_00_00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_ENG-1:0]  eng_sel_i,
  output logic              cal_en_o,
  output logic              clr_no,
  output logic [N_ENG-1:0]  ser_en_o,
  output logic [N_BANK-1:0] upd_en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned EW = (N_ENG > 1) ? $clog2(N_ENG) : 1;

  logic              xfer_end;
  logic [EW-1:0]     eng;
  logic [N_BANK-1:0] hold;

  term_cal_fsm #(
    .N_ENG      (N_ENG),
    .CAL_CYCLES (CAL_CYCLES),
    .CODE_BITS  (CODE_BITS)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sel_i      (eng_sel_i),
    .hold_i     (|hold),
    .cal_en_o   (cal_en_o),
    .clr_no     (clr_no),
    .ser_en_o   (ser_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .xfer_end_o (xfer_end),
    .eng_o      (eng)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic load;
    assign load = xfer_end && (8'(eng) == BANK_MAP[b*8 +: 8]);
    term_cal_upd #(.UPD_CYCLES(UPD_CYCLES)) i_upd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .upd_o  (upd_en_o[b]),
      .hold_o (hold[b])
    );
  end
endmodule

// File: rtl/term_cal_seq_chk.sv
module term_cal_seq_chk #(
  parameter int unsigned N_ENG      = 4,
  parameter int unsigned N_BANK     = 6,
  parameter int unsigned CAL_CYCLES = 1000,
  parameter int unsigned CODE_BITS  = 28,
  parameter logic [N_BANK*8-1:0] BANK_MAP = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cal_en_o,
  input logic              clr_no,
  input logic [N_ENG-1:0]  ser_en_o,
  input logic [N_BANK-1:0] upd_en_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int unsigned CMAX = (CAL_CYCLES > CODE_BITS) ? CAL_CYCLES : CODE_BITS;
  localparam int unsigned RW = $clog2(CMAX + 2);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (ser_en_o != '0)  run_q <= run_q + 1'b1;
    else                      run_q <= '0;
  end

  // R6
  ser_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ser_en_o));

  // R3
  ser_rise_prep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_o != '0 && $past(ser_en_o) == '0 && cal_en_o) |-> ($past(!clr_no) && $past(cal_en_o)));

  // R3
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_no |-> (cal_en_o && ser_en_o == '0));

  // R4
  cal_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_en_o) |-> ($past(ser_en_o) == '0));

  // R4
  xfer_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_o != '0 && !cal_en_o) |-> !$past(cal_en_o));

  // R5
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_o == '0 && $past(ser_en_o) != '0) |->
      (run_q == RW'(CAL_CYCLES) || run_q == RW'(CODE_BITS)));

  // R5
  no_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_o != '0 && $past(ser_en_o) != '0) |-> (ser_en_o == $past(ser_en_o)));

  // R8
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R8
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_o != '0 || cal_en_o || upd_en_o != '0) |-> busy_o);

  for (genvar b = 0; b < N_BANK; b++) begin : g_upd
    localparam int unsigned ENG = BANK_MAP[b*8 +: 8];
    // R7
    upd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(upd_en_o[b]) |-> (!ser_en_o[ENG] && $past(ser_en_o[ENG]) && !cal_en_o));
  end
endmodule

bind term_cal_seq term_cal_seq_chk #(
  .N_ENG      (N_ENG),
  .N_BANK     (N_BANK),
  .CAL_CYCLES (CAL_CYCLES),
  .CODE_BITS  (CODE_BITS),
  .BANK_MAP   (BANK_MAP)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cal_en_o (cal_en_o),
  .clr_no   (clr_no),
  .ser_en_o (ser_en_o),
  .upd_en_o (upd_en_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/test_term_cal_seq.sv
module test_term_cal_seq;
  localparam int CLK_NS = 10;
  localparam int NE     = 4;
  localparam int NB     = 6;
  localparam int CAL    = 1000;
  localparam int BITS   = 28;
  localparam int UPD    = (25 + CLK_NS - 1) / CLK_NS;
  localparam logic [NB*8-1:0] MAP = 48'h03_03_02_01_00_00;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start = 1'b0;
  logic [NE-1:0] sel = '0;
  logic          cal_en, clr_n, busy, done;
  logic [NE-1:0] ser;
  logic [NB-1:0] upd;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lst[NE];
  int pos[NE];
  int m = 0;

  always #(CLK_NS/2) clk = ~clk;

  term_cal_seq #(
    .N_ENG(NE), .N_BANK(NB), .CAL_CYCLES(CAL), .CODE_BITS(BITS),
    .UPD_CYCLES(UPD), .BANK_MAP(MAP)
  ) i_term_cal_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .eng_sel_i(sel),
    .cal_en_o(cal_en), .clr_no(clr_n), .ser_en_o(ser), .upd_en_o(upd),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL R8 watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int x0();
    return m * (CAL + 1) + 2;
  endfunction

  function automatic int end_cyc();
    return x0() + (m - 1) * (BITS + 1) + BITS + UPD;
  endfunction

  function automatic logic [NE-1:0] exp_ser(int c);
    for (int j = 0; j < m; j++) begin
      int b = j * (CAL + 1);
      if (c >= b + 1 && c <= b + CAL) return NE'(1) << lst[j];
    end
    for (int j = 0; j < m; j++) begin
      int s = x0() + j * (BITS + 1);
      if (c >= s && c < s + BITS) return NE'(1) << lst[j];
    end
    return '0;
  endfunction

  function automatic logic exp_cal(int c);
    return (m > 0) && c >= 0 && c <= m * (CAL + 1);
  endfunction

  function automatic logic exp_clr_n(int c);
    for (int j = 0; j < m; j++) if (c == j * (CAL + 1)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [NB-1:0] exp_upd(int c);
    logic [NB-1:0] r = '0;
    for (int b = 0; b < NB; b++) begin
      int e = int'(MAP[b*8 +: 8]);
      if (pos[e] >= 0) begin
        int s = x0() + pos[e] * (BITS + 1) + BITS;
        if (c >= s && c < s + UPD) r[b] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, "cal_en", 32'(cal_en), 0);
    chk(req, "clr_n", 32'(clr_n), 1);
    chk(req, "ser", 32'(ser), 0);
    chk(req, "upd", 32'(upd), 0);
    chk(req, "busy", 32'(busy), 0);
    chk(req, "done", 32'(done), 0);
  endtask

  task automatic check_cycle(input int c, input bit inj);
    string ts, tc, tu, tb;
    ts = (c <= m * (CAL + 1)) ? "R3" : "R5";
    tc = "R4"; tu = "R7"; tb = "R8";
    if (inj) begin ts = "R9"; tc = "R9"; tu = "R9"; tb = "R9"; end
    chk(ts, "ser", 32'(ser), 32'(exp_ser(c)));
    chk(tc, "cal_en", 32'(cal_en), 32'(exp_cal(c)));
    chk((c < m * (CAL + 1)) ? "R3" : tc, "clr_n", 32'(clr_n), 32'(exp_clr_n(c)));
    chk(tu, "upd", 32'(upd), 32'(exp_upd(c)));
    chk(tb, "busy", 32'(busy), 32'(c < end_cyc()));
    chk(tb, "done", 32'(done), 32'(c == end_cyc()));
    chk("R6", "ser_onehot", 32'($countones(ser) <= 1), 1);
  endtask

  task automatic run_seq(input logic [NE-1:0] s, input bit inject);
    int e;
    bit inj_prev;
    m = 0;
    for (int k = 0; k < NE; k++) begin
      pos[k] = -1;
      if (s[k]) begin lst[m] = k; pos[k] = m; m++; end
    end
    e = end_cyc();
    start = 1'b1; sel = s;
    @(negedge clk);
    start = 1'b0;
    inj_prev = 1'b0;
    for (int c = 0; c <= e + 2; c++) begin
      check_cycle(c, inj_prev);
      inj_prev = 1'b0;
      if (inject && c < e - 1 && $urandom_range(7) == 0) begin
        start = 1'b1; sel = NE'($urandom); inj_prev = 1'b1;
      end else begin
        start = 1'b0; sel = '0;
      end
      @(negedge clk);
    end
    start = 1'b0; sel = '0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int k = 0; k < NE; k++) pos[k] = -1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check_idle("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");

    // R2 zero mask ignored
    start = 1'b1; sel = '0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin check_idle("R2"); @(negedge clk); end

    run_seq(4'b0001, 1'b0);
    run_seq(4'b1000, 1'b0);
    run_seq(4'b0101, 1'b0);
    run_seq(4'b1111, 1'b0);
    run_seq(4'b0110, 1'b1);  // R9 directed overlap
    for (int r = 0; r < 6; r++) begin
      logic [NE-1:0] s;
      s = NE'($urandom);
      if (s == '0) s = 4'b1010;
      run_seq(s, r[0]);
    end

    check_idle("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule